// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the 8-bit arithmetic and logic unit of an accumulator-style microcontroller datapath. It is purely combinational. It takes the accumulator byte, a second operand byte, the three incoming status flags and a 4-bit operation code. It returns the result byte, the new carry (CY), auxiliary carry (AC) and overflow (OV) values, and a separate write enable for each flag. The surrounding datapath writes the result back to the accumulator. It updates a flag in the status register only when that flag's enable is high.

The block covers binary add with and without carry-in, subtract with borrow, bitwise AND, OR and XOR, and clear and complement of the accumulator. It also covers increment, decrement, four rotates, nibble swap and BCD decimal adjust. Many operations must leave the status flags alone. For those, the enables stay low and each flag output repeats its incoming value, so a careless write-back cannot corrupt the flags.

Top module: `acc_alu`

## Requirements
- R1: `op_sel` selects the operation: 0 add, 1 add-with-carry, 2 subtract-with-borrow, 3 AND, 4 OR, 5 XOR, 6 clear, 7 complement, 8 increment, 9 decrement, 10 rotate left, 11 rotate left through carry, 12 rotate right, 13 rotate right through carry, 14 nibble swap, 15 decimal adjust. Add returns `acc_in + opnd_in` modulo 256. CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R2: Add-with-carry returns `acc_in + opnd_in + cy_in` modulo 256. Its flags follow the add rules with the carry-in counted in. Example: 0xC3 + 0xAA with carry-in 1 gives 0x6E with CY=1, AC=0 and OV=1.
- R3: For add, add-with-carry and subtract-with-borrow, OV is set exactly when the signed (two's complement) result falls outside -128..127. This is equivalent to the carry into bit 7 differing from the carry out of bit 7. Example: 0xC3 + 0xAA gives 0x6D with CY=1, OV=1 and AC=0.
- R4: Subtract-with-borrow returns `acc_in - opnd_in - cy_in` modulo 256. CY is set when the unsigned difference is negative, and AC is set when the low nibble needs a borrow.
- R5: AND, OR and XOR combine `acc_in` with `opnd_in` bitwise. They raise no flag enable.
- R6: Clear returns 0x00 and complement returns the one's complement of `acc_in`. Neither raises a flag enable.
- R7: Increment and decrement wrap modulo 256 (0xFF+1=0x00, 0x00-1=0xFF) and raise no flag enable.
- R8: Plain rotate left moves bit 7 into bit 0, and plain rotate right moves bit 0 into bit 7. Neither raises a flag enable.
- R9: Rotate left through carry shifts `cy_in` into bit 0 and returns the old bit 7 as CY. Rotate right through carry shifts `cy_in` into bit 7 and returns the old bit 0 as CY. Only the CY enable is raised.
- R10: Swap exchanges the high and low nibbles of `acc_in` and raises no flag enable.
- R11: Decimal adjust works in two steps. First it adds 0x06 if the low nibble exceeds 9 or `ac_in` is 1; a carry out of bit 7 from this step sets CY. Then it adds 0x60 if the resulting high nibble exceeds 9 or CY is already set, and in that case it sets CY. CY is never cleared from `cy_in`. Only the CY enable is raised.
- R12: Add, add-with-carry and subtract-with-borrow raise all three enables. Whenever a flag's enable is low, that flag's output equals its incoming value.
- R13: All outputs depend only on the present inputs, with no internal state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_sel | input | 4 | Operation code (see R1) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand byte |
| cy_in | input | 1 | Current carry flag |
| ac_in | input | 1 | Current auxiliary carry flag |
| ov_in | input | 1 | Current overflow flag |
| result | output | 8 | Result byte |
| cy_out | output | 1 | New carry value |
| ac_out | output | 1 | New auxiliary carry value |
| ov_out | output | 1 | New overflow value |
| cy_we | output | 1 | Carry write enable |
| ac_we | output | 1 | Auxiliary carry write enable |
| ov_we | output | 1 | Overflow write enable |

## Verification
The block holds no registers, so every result and flag is due in the same cycle its inputs are applied, zero clock edges later. The bench changes the inputs on the falling edge of its clock. It samples all outputs one nanosecond later, well before the next rising edge, so no check depends on edge ordering. Expected values come from an integer model in the bench. That model decides overflow from the signed range, borrow from a negative difference, and the rotates and swap from multiply and divide arithmetic.

// File: rtl/acc_alu_pkg.sv
`timescale 1ns/1ps
package acc_alu_pkg;
  localparam int ALU_W    = 8;
  localparam int OP_W     = 4;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUBB = 4'd2,
    OP_AND  = 4'd3,
    OP_OR   = 4'd4,
    OP_XOR  = 4'd5,
    OP_CLR  = 4'd6,
    OP_CPL  = 4'd7,
    OP_INC  = 4'd8,
    OP_DEC  = 4'd9,
    OP_RL   = 4'd10,
    OP_RLC  = 4'd11,
    OP_RR   = 4'd12,
    OP_RRC  = 4'd13,
    OP_SWAP = 4'd14,
    OP_DA   = 4'd15
  } alu_op_e;

  // result-source select used by the top-level mux
  typedef enum logic [1:0] {
    SRC_ARITH = 2'd0,
    SRC_BITS  = 2'd1,
    SRC_DECA  = 2'd2
  } res_src_e;

  typedef struct packed {
    res_src_e src;
    logic     cy_we;
    logic     ac_we;
    logic     ov_we;
    logic     cy_from_rot;
  } flag_ctl_t;

  // true when a nibble value is not a decimal digit
  function automatic logic nib_over9(input logic [3:0] n);
    return n > 4'd9;
  endfunction

  // true for operations whose flags must stay untouched
  function automatic logic op_keeps_flags(input alu_op_e op);
    return !(op inside {OP_ADD, OP_ADDC, OP_SUBB, OP_RLC, OP_RRC, OP_DA});
  endfunction
endpackage

// File: rtl/acc_alu_addsub.sv
`timescale 1ns/1ps
module acc_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_flag,
  input  logic         use_carry,
  input  logic         is_sub,
  output logic [W-1:0] sum,
  output logic         cy,
  output logic         ac,
  output logic         ov
);
  localparam int H = W / 2;

  logic [W-1:0] b_eff;
  logic         ci_raw;
  logic         ci;
  logic         c_half;   // carry out of the low nibble
  logic         c_into_msb;
  logic         c_out;

  // carry out of the low n bits of a + b + c
  function automatic logic low_carry(input logic [W-1:0] x, input logic [W-1:0] y,
                                     input logic c, input int n);
    logic [W:0] acc;
    acc = '0;
    for (int i = 0; i < W; i++) begin
      if (i < n) acc[i] = x[i] ^ y[i] ^ (i == 0 ? c : acc[W]);
      if (i < n) acc[W] = (x[i] & y[i]) | (x[i] & (i == 0 ? c : acc[W])) |
                          (y[i] & (i == 0 ? c : acc[W]));
    end
    return acc[W];
  endfunction

  function automatic logic [W:0] wide_add(input logic [W-1:0] x, input logic [W-1:0] y,
                                          input logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  always_comb begin
    ci_raw     = use_carry & carry_flag;
    b_eff      = is_sub ? ~b : b;
    ci         = ci_raw ^ is_sub;
    {c_out, sum} = wide_add(a, b_eff, ci);
    c_half     = low_carry(a, b_eff, ci, H);
    c_into_msb = low_carry(a, b_eff, ci, W - 1);
    cy         = c_out ^ is_sub;
    ac         = c_half ^ is_sub;
    ov         = c_into_msb ^ c_out;
  end

  always_comb begin
    // R3
    ov_sign_chk: assert (!ov || ((a[W-1] == (b[W-1] ^ is_sub)) && (sum[W-1] != a[W-1])))
      else $error("overflow flagged without sign violation");
    // R4
    borrow_cmp_chk: assert (!is_sub || (cy == ({1'b0, a} < ({1'b0, b} + {{W{1'b0}}, ci_raw}))))
      else $error("borrow disagrees with unsigned compare");
  end
endmodule

// File: rtl/acc_alu_bitops.sv
`timescale 1ns/1ps
module acc_alu_bitops
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_flag,
  output logic [W-1:0] res,
  output logic         cy_rot
);
  localparam int H = W / 2;

  logic [W-1:0] rot_l, rot_r, rot_lc, rot_rc, swapped;

  // each rotated vector built bit by bit
  for (genvar g = 0; g < W; g++) begin : g_rot
    if (g == 0) begin : g_lsb
      assign rot_l[g]  = a[W-1];
      assign rot_lc[g] = carry_flag;
    end else begin : g_lo
      assign rot_l[g]  = a[g-1];
      assign rot_lc[g] = a[g-1];
    end
    if (g == W - 1) begin : g_msb
      assign rot_r[g]  = a[0];
      assign rot_rc[g] = carry_flag;
    end else begin : g_hi
      assign rot_r[g]  = a[g+1];
      assign rot_rc[g] = a[g+1];
    end
  end

  assign swapped = {a[H-1:0], a[W-1:H]};

  always_comb begin
    cy_rot = carry_flag;
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLR:  res = '0;
      OP_CPL:  res = ~a;
      OP_INC:  res = a + {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  res = a - {{(W-1){1'b0}}, 1'b1};
      OP_RL:   res = rot_l;
      OP_RR:   res = rot_r;
      OP_RLC:  begin res = rot_lc; cy_rot = a[W-1]; end
      OP_RRC:  begin res = rot_rc; cy_rot = a[0];   end
      OP_SWAP: res = swapped;
      default: res = a;
    endcase
  end

  always_comb begin
    // R9
    rot_thru_ones_chk: assert (!(op inside {OP_RLC, OP_RRC}) ||
                               ($countones({cy_rot, res}) == $countones({carry_flag, a})))
      else $error("rotate through carry lost or gained a bit");
    // R8
    rot_plain_ones_chk: assert (!(op inside {OP_RL, OP_RR, OP_SWAP}) ||
                                ($countones(res) == $countones(a)))
      else $error("plain rotate or swap changed bit count");
  end
endmodule

// File: rtl/acc_alu_decadj.sv
`timescale 1ns/1ps
module acc_alu_decadj
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic         cy_in,
  input  logic         ac_in,
  output logic [W-1:0] res,
  output logic         cy
);
  localparam int H = W / 2;
  localparam logic [W:0]   LO_FIX = (W+1)'(6);
  localparam logic [W-1:0] HI_FIX = W'(6 << H);

  logic [W:0]   step1;
  logic         cy_step1;
  logic         fix_lo;
  logic         fix_hi;

  always_comb begin
    fix_lo   = nib_over9(a[3:0]) | ac_in;
    step1    = {1'b0, a} + (fix_lo ? LO_FIX : '0);
    cy_step1 = cy_in | step1[W];
    fix_hi   = nib_over9(step1[W-1:W-4]) | cy_step1;
    res      = step1[W-1:0] + (fix_hi ? HI_FIX : '0);
    cy       = cy_step1 | fix_hi;
  end

  always_comb begin
    // R11
    da_sticky_chk: assert (!cy_in || cy)
      else $error("decimal adjust cleared carry");
    // R11
    da_valid_bcd_chk: assert (cy_in || ac_in || nib_over9(a[3:0]) || nib_over9(a[W-1:W-4]) ||
                              ((res == a) && !cy))
      else $error("decimal adjust altered a valid BCD byte");
  end
endmodule

// File: rtl/acc_alu.sv
`timescale 1ns/1ps
module acc_alu
  import acc_alu_pkg::*;
(
  input  logic [3:0] op_sel,
  input  logic [7:0] acc_in,
  input  logic [7:0] opnd_in,
  input  logic       cy_in,
  input  logic       ac_in,
  input  logic       ov_in,
  output logic [7:0] result,
  output logic       cy_out,
  output logic       ac_out,
  output logic       ov_out,
  output logic       cy_we,
  output logic       ac_we,
  output logic       ov_we
);
  localparam int W = ALU_W;

  alu_op_e    op;
  flag_ctl_t  ctl;

  logic [W-1:0] arith_sum, bits_res, deca_res;
  logic         arith_cy, arith_ac, arith_ov;
  logic         bits_cy, deca_cy;
  logic         use_carry, is_sub;

  assign op        = alu_op_e'(op_sel);
  assign use_carry = (op == OP_ADDC) || (op == OP_SUBB);
  assign is_sub    = (op == OP_SUBB);

  acc_alu_addsub #(.W(W)) u_addsub (
    .a(acc_in), .b(opnd_in), .carry_flag(cy_in), .use_carry(use_carry),
    .is_sub(is_sub), .sum(arith_sum), .cy(arith_cy), .ac(arith_ac), .ov(arith_ov)
  );

  acc_alu_bitops #(.W(W)) u_bitops (
    .op(op), .a(acc_in), .b(opnd_in), .carry_flag(cy_in),
    .res(bits_res), .cy_rot(bits_cy)
  );

  acc_alu_decadj #(.W(W)) u_decadj (
    .a(acc_in), .cy_in(cy_in), .ac_in(ac_in), .res(deca_res), .cy(deca_cy)
  );

  // decode: result source and flag enables
  always_comb begin
    ctl = '{src: SRC_BITS, cy_we: 1'b0, ac_we: 1'b0, ov_we: 1'b0, cy_from_rot: 1'b0};
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        ctl.src   = SRC_ARITH;
        ctl.cy_we = 1'b1;
        ctl.ac_we = 1'b1;
        ctl.ov_we = 1'b1;
      end
      OP_RLC, OP_RRC: begin
        ctl.cy_we       = 1'b1;
        ctl.cy_from_rot = 1'b1;
      end
      OP_DA: begin
        ctl.src   = SRC_DECA;
        ctl.cy_we = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    result = bits_res;
    cy_out = cy_in;
    ac_out = ac_in;
    ov_out = ov_in;
    unique case (ctl.src)
      SRC_ARITH: begin
        result = arith_sum;
        cy_out = arith_cy;
        ac_out = arith_ac;
        ov_out = arith_ov;
      end
      SRC_DECA: begin
        result = deca_res;
        cy_out = deca_cy;
      end
      default: if (ctl.cy_from_rot) cy_out = bits_cy;
    endcase
  end

  assign cy_we = ctl.cy_we;
  assign ac_we = ctl.ac_we;
  assign ov_we = ctl.ov_we;

  always_comb begin
    // R12
    flag_hold_chk: assert (!op_keeps_flags(op) ||
                           (!cy_we && !ac_we && !ov_we &&
                            ({cy_out, ac_out, ov_out} == {cy_in, ac_in, ov_in})))
      else $error("flag-neutral operation disturbed flags");
    // R12
    we_nesting_chk: assert (!ov_we || (ac_we && cy_we))
      else $error("overflow enable without carry enables");
  end
endmodule

// File: tb/acc_alu_tb_top.sv
`timescale 1ns/1ps
module acc_alu_tb_top;
  logic       clk = 1'b0;
  logic [3:0] op_sel;
  logic [7:0] acc_in, opnd_in;
  logic       cy_in, ac_in, ov_in;
  logic [7:0] result;
  logic       cy_out, ac_out, ov_out, cy_we, ac_we, ov_we;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  acc_alu dut_i (
    .op_sel(op_sel), .acc_in(acc_in), .opnd_in(opnd_in),
    .cy_in(cy_in), .ac_in(ac_in), .ov_in(ov_in),
    .result(result), .cy_out(cy_out), .ac_out(ac_out), .ov_out(ov_out),
    .cy_we(cy_we), .ac_we(ac_we), .ov_we(ov_we)
  );

  // integer reference model built from the requirements
  task automatic model(input int op, input int a, input int b, input int c,
                       input int h, input int v,
                       output int r, output int ec, output int eh, output int ev,
                       output int wc, output int wh, output int wv);
    int sa, sb, s, t;
    r = a; ec = c; eh = h; ev = v; wc = 0; wh = 0; wv = 0;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    case (op)
      0, 1: begin
        t = (op == 1) ? c : 0;
        s = a + b + t;
        r = s % 256; ec = (s > 255); eh = ((a % 16 + b % 16 + t) > 15);
        s = sa + sb + t; ev = (s > 127 || s < -128);
        wc = 1; wh = 1; wv = 1;
      end
      2: begin
        s = a - b - c;
        r = (s + 256) % 256; ec = (s < 0); eh = ((a % 16 - b % 16 - c) < 0);
        s = sa - sb - c; ev = (s > 127 || s < -128);
        wc = 1; wh = 1; wv = 1;
      end
      3:  r = a & b;
      4:  r = a | b;
      5:  r = a ^ b;
      6:  r = 0;
      7:  r = 255 - a;
      8:  r = (a + 1) % 256;
      9:  r = (a + 255) % 256;
      10: r = (a * 2) % 256 + a / 128;
      11: begin r = (a * 2) % 256 + c; ec = a / 128; wc = 1; end
      12: r = a / 2 + (a % 2) * 128;
      13: begin r = a / 2 + c * 128; ec = a % 2; wc = 1; end
      14: r = (a % 16) * 16 + a / 16;
      default: begin
        t = a;
        if ((t % 16) > 9 || h == 1) t = t + 6;
        if (t > 255) ec = 1;
        t = t % 256;
        if ((t / 16) > 9 || ec == 1) begin t = (t + 96) % 256; ec = 1; end
        r = t; wc = 1;
      end
    endcase
  endtask

  function automatic string req_of(input int op);
    case (op)
      0: return "R1"; 1: return "R2"; 2: return "R4";
      3, 4, 5: return "R5"; 6, 7: return "R6"; 8, 9: return "R7";
      10, 12: return "R8"; 11, 13: return "R9"; 14: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic apply(input int op, input int a, input int b,
                       input int c, input int h, input int v);
    @(negedge clk);
    op_sel = 4'(op); acc_in = 8'(a); opnd_in = 8'(b);
    cy_in = 1'(c); ac_in = 1'(h); ov_in = 1'(v);
    #1;
  endtask

  task automatic check(input string req, input int er, input int ec, input int eh,
                       input int ev, input int wc, input int wh, input int wv);
    logic [13:0] act, exp_v;
    act   = {result, cy_out, ac_out, ov_out, cy_we, ac_we, ov_we};
    exp_v = {8'(er), 1'(ec), 1'(eh), 1'(ev), 1'(wc), 1'(wh), 1'(wv)};
    n_tests++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%02h b=%02h: got res=%02h cy/ac/ov=%b%b%b we=%b%b%b, exp res=%02h cy/ac/ov=%b%b%b we=%b%b%b",
               req, op_sel, acc_in, opnd_in, act[13:6], act[5], act[4], act[3],
               act[2], act[1], act[0], exp_v[13:6], exp_v[5], exp_v[4], exp_v[3],
               exp_v[2], exp_v[1], exp_v[0]);
    end
  endtask

  // run one vector against the model
  task automatic run_model(input string req, input int op, input int a, input int b,
                           input int c, input int h, input int v);
    int r, ec, eh, ev, wc, wh, wv;
    apply(op, a, b, c, h, v);
    model(op, a, b, c, h, v, r, ec, eh, ev, wc, wh, wv);
    check(req, r, ec, eh, ev, wc, wh, wv);
  endtask

  task automatic t_idle;  // all-zero inputs, R13: settles in the same cycle
    apply(0, 0, 0, 0, 0, 0);
    check("R13", 8'h00, 0, 0, 0, 1, 1, 1);
  endtask

  task automatic t_add_examples;
    apply(0, 8'hC3, 8'hAA, 0, 1, 0);
    check("R1/R3", 8'h6D, 1, 0, 1, 1, 1, 1);
    apply(1, 8'hC3, 8'hAA, 1, 0, 0);
    check("R2", 8'h6E, 1, 0, 1, 1, 1, 1);
    apply(0, 8'h0F, 8'h01, 1, 0, 1);      // nibble carry only, carry-in ignored
    check("R1", 8'h10, 0, 1, 0, 1, 1, 1);
    apply(0, 8'h40, 8'h40, 0, 0, 0);      // positive overflow, R3
    check("R3", 8'h80, 0, 0, 1, 1, 1, 1);
  endtask

  task automatic t_subb;
    apply(2, 8'hC9, 8'h54, 1, 0, 0);
    check("R4/R3", 8'h74, 0, 0, 1, 1, 1, 1);
    apply(2, 8'h00, 8'h00, 1, 0, 0);      // borrow from carry alone
    check("R4", 8'hFF, 1, 1, 0, 1, 1, 1);
    apply(2, 8'h55, 8'h55, 0, 1, 1);
    check("R4", 8'h00, 0, 0, 0, 1, 1, 1);
  endtask

  task automatic t_logic_flags;  // flags pass through unchanged, R12
    apply(3, 8'hC3, 8'h55, 1, 0, 1);
    check("R5/R12", 8'h41, 1, 0, 1, 0, 0, 0);
    apply(5, 8'hF0, 8'hFF, 0, 1, 0);
    check("R5/R12", 8'h0F, 0, 1, 0, 0, 0, 0);
    apply(6, 8'h5C, 8'h12, 1, 1, 1);
    check("R6", 8'h00, 1, 1, 1, 0, 0, 0);
    apply(7, 8'h5C, 8'h00, 0, 0, 0);
    check("R6", 8'hA3, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_incdec;
    apply(8, 8'hFF, 8'h00, 0, 0, 0);
    check("R7", 8'h00, 0, 0, 0, 0, 0, 0);
    apply(9, 8'h00, 8'h00, 1, 1, 1);
    check("R7", 8'hFF, 1, 1, 1, 0, 0, 0);
  endtask

  task automatic t_rotate_swap;
    apply(10, 8'h81, 8'h00, 0, 0, 0);
    check("R8", 8'h03, 0, 0, 0, 0, 0, 0);
    apply(12, 8'h01, 8'h00, 1, 0, 0);
    check("R8", 8'h80, 1, 0, 0, 0, 0, 0);
    apply(11, 8'h80, 8'h00, 1, 0, 0);
    check("R9", 8'h01, 1, 0, 0, 1, 0, 0);
    apply(13, 8'h02, 8'h00, 1, 1, 0);
    check("R9", 8'h81, 0, 1, 0, 1, 0, 0);
    apply(14, 8'hA5, 8'h00, 0, 0, 0);
    check("R10", 8'h5A, 0, 0, 0, 0, 0, 0);
  endtask

  task automatic t_decadj;
    apply(15, 8'hBD, 8'h00, 0, 0, 0);    // 0x56 + 0x67 -> 0x23 carry
    check("R11", 8'h23, 1, 0, 0, 1, 0, 0);
    apply(15, 8'h99, 8'h00, 0, 0, 0);    // valid BCD untouched
    check("R11", 8'h99, 0, 0, 0, 1, 0, 0);
    apply(15, 8'h12, 8'h00, 0, 1, 0);
    check("R11", 8'h18, 0, 1, 0, 1, 0, 0);
    apply(15, 8'h34, 8'h00, 1, 0, 0);    // carry sticks
    check("R11", 8'h94, 1, 0, 0, 1, 0, 0);
    apply(15, 8'hFA, 8'h00, 0, 0, 0);    // first step overflows out of bit 7
    check("R11", 8'h60, 1, 0, 0, 1, 0, 0);
  endtask

  task automatic t_sweep;  // every op over a spread of bytes and flags
    int a, b;
    a = 8'h1D; b = 8'hB7;
    for (int k = 0; k < 48; k++) begin
      for (int op = 0; op < 16; op++) begin
        run_model(req_of(op), op, a, b, k % 2, (k / 2) % 2, (k / 4) % 2);
      end
      a = (a * 37 + 11) % 256;
      b = (b * 61 + 97) % 256;
    end
  endtask

  initial begin
    fork
      begin
        t_idle();
        t_add_examples();
        t_subb();
        t_logic_flags();
        t_incdec();
        t_rotate_swap();
        t_decadj();
        t_sweep();
      end
      begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
      end
    join_any
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule